// File: doc/BRIEF.md
# Two-Way Write-Back Cache Tag Array with Copyback Buffer

This block holds the tag and state side of a two-way set-associative write-back data cache. The cache has 256 sets of 16-byte lines. For each way and set it stores a tag, a valid bit, a modified bit and a lock bit. Each set also has one least-recently-used bit. A lookup port reports hit and hit way in the same cycle. A fill request allocates a way for the current access address. A write that hits, or a fill made for a write, marks the line modified. The data array sits next to the block. For a fill it is given the victim way and returns that line's four words.

When a fill replaces a line that is valid and modified, the block captures the four data words and the rebuilt line address into a copyback buffer. It then raises a one-cycle copyback pulse. A read-only diagnostic port decodes a command word and returns one formatted word a cycle later. The command selects either one way's tag and state, or one word of the copyback buffer. A write attempt on the diagnostic port raises an error pulse and changes nothing.

Top module: `wbt_tag_array`

## Requirements
- R1: After reset every line reads invalid, unlocked and unmodified with a zero tag, every LRU bit is 0, all copyback buffer words read zero, and no hit is reported.
- R2: The access address splits into tag = addr[31:12], set = addr[11:4] and byte offset = addr[3:0]. `hit_o` is high in the same cycle when `acc_valid_i` is high and a valid way of that set holds the tag. `hit_way_o` then names that way.
- R3: On a fill the victim is chosen in this order: way 0 if invalid, then way 1 if invalid, then the LRU way if unlocked, then the other way if unlocked. If both ways are valid and locked, `fill_blocked_o` is high in that cycle and no state changes.
- R4: A lookup hit (without a fill) or a completed fill sets the set's LRU bit to the way that was not used.
- R5: A lookup hit with `acc_write_i` high marks the hit line modified. A fill stores the new tag as valid, with modified = `acc_write_i` and lock = `fill_lock_i`.
- R6: A fill that replaces a valid modified line loads the copyback buffer. The words are taken from `vic_line_i` (word i = bits [32i+31:32i]) and the address is {old tag, set, 4'b0000}. `cb_valid_o` is high for the one cycle after that edge. Replacing a clean or invalid line leaves the buffer unchanged and gives no pulse.
- R7: `dg_rd_i` with `dg_cmd_i[9]`=0 returns, one cycle later on `dg_data_o`, the way `dg_cmd_i[8]` of set `dg_cmd_i[7:0]`. The format is: tag in [31:12], zeros in [11:4], valid [3], lock [2], the set's LRU bit [1] and modified [0].
- R8: `dg_rd_i` with `dg_cmd_i[9]`=1 uses `dg_cmd_i[7:0]` as selector. Values 0x00–0x03 return buffered words 0–3, 0x04 returns the buffered address, and 0x05–0xFF return zero, one cycle later.
- R9: `dg_wr_i` raises `dg_err_o` for the one following cycle and changes no tag, state or buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Lookup request |
| acc_write_i | input | 1 | Access is a write (marks modified on hit or fill) |
| acc_addr_i | input | 32 | Physical access address |
| hit_o | output | 1 | Lookup hit |
| hit_way_o | output | 1 | Way that hit |
| fill_i | input | 1 | Allocate a line for acc_addr_i |
| fill_lock_i | input | 1 | Lock the filled line |
| fill_blocked_o | output | 1 | Fill refused, both ways locked |
| vic_way_o | output | 1 | Victim way for the data array |
| vic_line_i | input | 128 | Victim line data from the data array |
| cb_valid_o | output | 1 | Copyback buffer just loaded |
| dg_rd_i | input | 1 | Diagnostic read strobe |
| dg_wr_i | input | 1 | Diagnostic write attempt (illegal) |
| dg_cmd_i | input | 10 | Diagnostic command {kind, way, set/select} |
| dg_data_o | output | 32 | Diagnostic read result |
| dg_err_o | output | 1 | Illegal diagnostic write flag |

## Verification
`hit_o`, `hit_way_o`, `fill_blocked_o` and `vic_way_o` are combinational. The bench drives inputs on the falling edge and samples these outputs 2 ns later, in the same cycle. `dg_data_o`, `dg_err_o` and `cb_valid_o` are due one edge after their stimulus, so they are sampled 2 ns after the next rising edge. The expected values are worked out before that edge, from the bench model's state as it was before the update. State changes from a hit or fill become visible to lookups and diagnostic reads from the following cycle. The bench model commits them only after computing the current cycle's expectations.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
  typedef enum logic {
    DG_TAG = 1'b0,
    DG_CB  = 1'b1
  } dg_kind_e;

  // number of state bits packed below the tag in a tag readout
  localparam int unsigned STATE_BITS = 4;
endpackage

// File: rtl/wbt_victim.sv
module wbt_victim (
  input  logic [1:0] vld_i,
  input  logic [1:0] lck_i,
  input  logic       lru_i,
  output logic       way_o,
  output logic       none_o
);
  always_comb begin
    way_o  = 1'b0;
    none_o = 1'b0;
    if (!vld_i[0])             way_o = 1'b0;
    else if (!vld_i[1])        way_o = 1'b1;
    else if (!lck_i[lru_i])    way_o = lru_i;
    else if (!lck_i[!lru_i])   way_o = !lru_i;
    else                       none_o = 1'b1;
  end
endmodule

// File: rtl/wbt_state.sv
module wbt_state #(
  parameter int unsigned SET_W = 8,
  parameter int unsigned TAG_W = 20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SET_W-1:0]      lk_set_i,
  input  logic                  touch_i,
  input  logic                  touch_way_i,
  input  logic                  touch_dirty_i,
  input  logic                  fill_i,
  input  logic                  fill_way_i,
  input  logic                  fill_lock_i,
  input  logic                  fill_dirty_i,
  input  logic [TAG_W-1:0]      fill_tag_i,
  output logic [1:0][TAG_W-1:0] lk_tag_o,
  output logic [1:0]            lk_vld_o,
  output logic [1:0]            lk_mod_o,
  output logic [1:0]            lk_lck_o,
  output logic                  lk_lru_o,
  input  logic [SET_W-1:0]      rd_set_i,
  input  logic                  rd_way_i,
  output logic [TAG_W-1:0]      rd_tag_o,
  output logic                  rd_vld_o,
  output logic                  rd_mod_o,
  output logic                  rd_lck_o,
  output logic                  rd_lru_o
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [1:0][TAG_W-1:0] rd_tag_w;
  logic [1:0]            rd_vld_w, rd_mod_w, rd_lck_w;
  logic [SETS-1:0]       lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q, mod_q, lck_q;
    logic             sel_fill, sel_touch;

    assign sel_fill  = fill_i  && (fill_way_i  == 1'(w));
    assign sel_touch = touch_i && (touch_way_i == 1'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
        vld_q <= '0;
        mod_q <= '0;
        lck_q <= '0;
      end else if (sel_fill) begin
        tag_q[lk_set_i] <= fill_tag_i;
        vld_q[lk_set_i] <= 1'b1;
        mod_q[lk_set_i] <= fill_dirty_i;
        lck_q[lk_set_i] <= fill_lock_i;
      end else if (sel_touch && touch_dirty_i) begin
        mod_q[lk_set_i] <= 1'b1;
      end
    end

    assign lk_tag_o[w] = tag_q[lk_set_i];
    assign lk_vld_o[w] = vld_q[lk_set_i];
    assign lk_mod_o[w] = mod_q[lk_set_i];
    assign lk_lck_o[w] = lck_q[lk_set_i];
    assign rd_tag_w[w] = tag_q[rd_set_i];
    assign rd_vld_w[w] = vld_q[rd_set_i];
    assign rd_mod_w[w] = mod_q[rd_set_i];
    assign rd_lck_w[w] = lck_q[rd_set_i];
  end

  // lru bit names the way to replace next
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (fill_i)  lru_q[lk_set_i] <= !fill_way_i;
    else if (touch_i) lru_q[lk_set_i] <= !touch_way_i;
  end

  assign lk_lru_o = lru_q[lk_set_i];
  assign rd_tag_o = rd_tag_w[rd_way_i];
  assign rd_vld_o = rd_vld_w[rd_way_i];
  assign rd_mod_o = rd_mod_w[rd_way_i];
  assign rd_lck_o = rd_lck_w[rd_way_i];
  assign rd_lru_o = lru_q[rd_set_i];
endmodule

// File: rtl/wbt_copyback.sv
module wbt_copyback #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SEL_W      = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [LINE_WORDS*WORD_W-1:0] line_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic                         pulse_o,
  output logic [WORD_W-1:0]            word_o
);
  logic [WORD_W-1:0] word_q [LINE_WORDS];
  logic [ADDR_W-1:0] addr_q;

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q[i] <= '0;
      else if (load_i) word_q[i] <= line_i[i*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= load_i;
      if (load_i) addr_q <= addr_i;
    end
  end

  // words first, then the address, anything above reads zero
  always_comb begin
    word_o = '0;
    for (int i = 0; i < LINE_WORDS; i++)
      if (sel_i == SEL_W'(i)) word_o = word_q[i];
    if (sel_i == SEL_W'(LINE_WORDS)) word_o = WORD_W'(addr_q);
  end
endmodule

// File: rtl/wbt_diag.sv
module wbt_diag #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned TAG_W  = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  wbt_pkg::dg_kind_e    kind_i,
  input  logic [TAG_W-1:0]     tag_i,
  input  logic                 vld_i,
  input  logic                 lck_i,
  input  logic                 lru_i,
  input  logic                 mod_i,
  input  logic [WORD_W-1:0]    cb_word_i,
  output logic [WORD_W-1:0]    data_o,
  output logic                 err_o
);
  logic [WORD_W-1:0] tag_word;

  always_comb begin
    tag_word = '0;
    tag_word[WORD_W-1 -: TAG_W] = tag_i;
    tag_word[wbt_pkg::STATE_BITS-1:0] = {vld_i, lck_i, lru_i, mod_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= wr_i;
      if (rd_i) data_o <= (kind_i == wbt_pkg::DG_CB) ? cb_word_i : tag_word;
    end
  end
endmodule

// File: rtl/wbt_tag_array.sv
module wbt_tag_array #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SET_W  = 8,
  parameter int unsigned OFS_W  = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       acc_valid_i,
  input  logic                                       acc_write_i,
  input  logic [ADDR_W-1:0]                          acc_addr_i,
  output logic                                       hit_o,
  output logic                                       hit_way_o,
  input  logic                                       fill_i,
  input  logic                                       fill_lock_i,
  output logic                                       fill_blocked_o,
  output logic                                       vic_way_o,
  input  logic [((1 << OFS_W) * 8)-1:0]              vic_line_i,
  output logic                                       cb_valid_o,
  input  logic                                       dg_rd_i,
  input  logic                                       dg_wr_i,
  input  logic [SET_W+1:0]                           dg_cmd_i,
  output logic [WORD_W-1:0]                          dg_data_o,
  output logic                                       dg_err_o
);
  localparam int unsigned TAG_W      = ADDR_W - SET_W - OFS_W;
  localparam int unsigned LINE_W     = (1 << OFS_W) * 8;
  localparam int unsigned LINE_WORDS = LINE_W / WORD_W;

  logic [SET_W-1:0]      lk_set;
  logic [TAG_W-1:0]      lk_tag;
  logic [1:0][TAG_W-1:0] way_tag;
  logic [1:0]            way_vld, way_mod, way_lck, match;
  logic                  set_lru, vic_way, vic_none, do_fill, do_touch, evict;
  logic [ADDR_W-1:0]     evict_addr;
  logic [TAG_W-1:0]      rd_tag;
  logic                  rd_vld, rd_mod, rd_lck, rd_lru;
  logic [WORD_W-1:0]     cb_word;
  wbt_pkg::dg_kind_e     dg_kind;

  assign lk_set = acc_addr_i[OFS_W +: SET_W];
  assign lk_tag = acc_addr_i[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign match[w] = way_vld[w] && (way_tag[w] == lk_tag);
  end

  assign hit_o     = acc_valid_i && (|match);
  assign hit_way_o = !match[0];

  wbt_victim u_victim (
    .vld_i  (way_vld),
    .lck_i  (way_lck),
    .lru_i  (set_lru),
    .way_o  (vic_way),
    .none_o (vic_none)
  );

  assign vic_way_o      = vic_way;
  assign fill_blocked_o = fill_i && vic_none;
  assign do_fill        = fill_i && !vic_none;
  assign do_touch       = hit_o && !fill_i;
  assign evict          = do_fill && way_vld[vic_way] && way_mod[vic_way];
  assign evict_addr     = {way_tag[vic_way], lk_set, OFS_W'(0)};

  wbt_state #(.SET_W(SET_W), .TAG_W(TAG_W)) u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lk_set_i      (lk_set),
    .touch_i       (do_touch),
    .touch_way_i   (hit_way_o),
    .touch_dirty_i (acc_write_i),
    .fill_i        (do_fill),
    .fill_way_i    (vic_way),
    .fill_lock_i   (fill_lock_i),
    .fill_dirty_i  (acc_write_i),
    .fill_tag_i    (lk_tag),
    .lk_tag_o      (way_tag),
    .lk_vld_o      (way_vld),
    .lk_mod_o      (way_mod),
    .lk_lck_o      (way_lck),
    .lk_lru_o      (set_lru),
    .rd_set_i      (dg_cmd_i[SET_W-1:0]),
    .rd_way_i      (dg_cmd_i[SET_W]),
    .rd_tag_o      (rd_tag),
    .rd_vld_o      (rd_vld),
    .rd_mod_o      (rd_mod),
    .rd_lck_o      (rd_lck),
    .rd_lru_o      (rd_lru)
  );

  wbt_copyback #(
    .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .ADDR_W(ADDR_W), .SEL_W(SET_W)
  ) u_cb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (evict),
    .line_i  (vic_line_i),
    .addr_i  (evict_addr),
    .sel_i   (dg_cmd_i[SET_W-1:0]),
    .pulse_o (cb_valid_o),
    .word_o  (cb_word)
  );

  assign dg_kind = wbt_pkg::dg_kind_e'(dg_cmd_i[SET_W+1]);

  wbt_diag #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_diag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (dg_rd_i),
    .wr_i      (dg_wr_i),
    .kind_i    (dg_kind),
    .tag_i     (rd_tag),
    .vld_i     (rd_vld),
    .lck_i     (rd_lck),
    .lru_i     (rd_lru),
    .mod_i     (rd_mod),
    .cb_word_i (cb_word),
    .data_o    (dg_data_o),
    .err_o     (dg_err_o)
  );
endmodule

// File: rtl/wbt_tag_array_chk.sv
module wbt_tag_array_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SET_W  = 8,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              hit_o,
  input logic              fill_i,
  input logic              fill_blocked_o,
  input logic              cb_valid_o,
  input logic              dg_rd_i,
  input logic              dg_wr_i,
  input logic [SET_W+1:0]  dg_cmd_i,
  input logic [WORD_W-1:0] dg_data_o,
  input logic              dg_err_o
);
  a_r9_err_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dg_wr_i |=> dg_err_o);

  a_r9_no_stray_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dg_wr_i |=> !dg_err_o);

  a_r6_pulse_needs_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cb_valid_o |-> $past(fill_i));

  a_r3_blocked_no_copyback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && fill_blocked_o) |=> !cb_valid_o);

  a_r8_high_select_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dg_rd_i && dg_cmd_i[SET_W+1] && (dg_cmd_i[SET_W-1:0] > SET_W'(4))) |=> (dg_data_o == '0));

  a_r2_hit_after_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fill_i && !fill_blocked_o) && acc_valid_i && (acc_addr_i == $past(acc_addr_i)))
      |-> hit_o);
endmodule

bind wbt_tag_array wbt_tag_array_chk #(
  .ADDR_W(ADDR_W), .SET_W(SET_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_valid_i    (acc_valid_i),
  .acc_addr_i     (acc_addr_i),
  .hit_o          (hit_o),
  .fill_i         (fill_i),
  .fill_blocked_o (fill_blocked_o),
  .cb_valid_o     (cb_valid_o),
  .dg_rd_i        (dg_rd_i),
  .dg_wr_i        (dg_wr_i),
  .dg_cmd_i       (dg_cmd_i),
  .dg_data_o      (dg_data_o),
  .dg_err_o       (dg_err_o)
);

// File: tb/wbt_tag_array_test.sv
module wbt_tag_array_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0]  acc_addr = '0;
  logic         fill = 1'b0, fill_lock = 1'b0;
  logic         dg_rd = 1'b0, dg_wr = 1'b0;
  logic [9:0]   dg_cmd = '0;
  logic [127:0] vic_line;
  logic         hit, hit_way, fill_blocked, vic_way, cb_valid, dg_err;
  logic [31:0]  dg_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [19:0] m_tag [2][256];
  bit          m_v [2][256];
  bit          m_m [2][256];
  bit          m_l [2][256];
  bit          m_lru [256];
  logic [31:0] m_cb [5];

  always #10 clk = ~clk;

  function automatic logic [127:0] line_pat(input logic w, input logic [7:0] s);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[i*32 +: 32] = {8'(8'hD0 + i), 7'd0, w, s, ~s};
    return l;
  endfunction

  assign vic_line = line_pat(vic_way, acc_addr[11:4]);

  wbt_tag_array uut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
    .hit_o(hit), .hit_way_o(hit_way),
    .fill_i(fill), .fill_lock_i(fill_lock), .fill_blocked_o(fill_blocked),
    .vic_way_o(vic_way), .vic_line_i(vic_line), .cb_valid_o(cb_valid),
    .dg_rd_i(dg_rd), .dg_wr_i(dg_wr), .dg_cmd_i(dg_cmd),
    .dg_data_o(dg_data), .dg_err_o(dg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [31:0] a, output bit w);
    logic [7:0] s = a[11:4];
    w = 1'b0;
    if (m_v[0][s] && m_tag[0][s] == a[31:12]) return 1'b1;
    w = 1'b1;
    if (m_v[1][s] && m_tag[1][s] == a[31:12]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_victim(input logic [7:0] s, output bit w);
    bit r = m_lru[s];
    w = 1'b0;
    if (!m_v[0][s]) begin w = 1'b0; return 1'b0; end
    if (!m_v[1][s]) begin w = 1'b1; return 1'b0; end
    if (!m_l[r][s]) begin w = r;    return 1'b0; end
    if (!m_l[!r][s]) begin w = !r;  return 1'b0; end
    return 1'b1;
  endfunction

  function automatic logic [31:0] m_diag(input logic [9:0] c);
    bit w = c[8];
    logic [7:0] s = c[7:0];
    if (!c[9]) return {m_tag[w][s], 8'd0, m_v[w][s], m_l[w][s], m_lru[s], m_m[w][s]};
    if (s < 8'd5) return m_cb[s];
    return 32'd0;
  endfunction

  // one clock cycle: drive, check same-cycle outputs, then next-edge outputs
  task automatic step(input bit av, input bit aw, input logic [31:0] ad, input bit fl,
                      input bit flk, input bit rd, input bit wr, input logic [9:0] cmd);
    bit hw, eh, vw, blk, ev;
    logic [7:0] s;
    logic [31:0] exp_dg;
    logic [127:0] ln;
    @(negedge clk);
    acc_valid = av; acc_write = aw; acc_addr = ad; fill = fl; fill_lock = flk;
    dg_rd = rd; dg_wr = wr; dg_cmd = cmd;
    #2;
    s   = ad[11:4];
    eh  = av && m_hit(ad, hw);
    blk = m_victim(s, vw);
    chk("R2 hit", 32'(hit), 32'(eh));
    if (eh) chk("R2 hit way", 32'(hit_way), 32'(hw));
    if (fl) chk("R3 blocked", 32'(fill_blocked), 32'(blk));
    if (fl && !blk) chk("R3 victim way", 32'(vic_way), 32'(vw));
    exp_dg = m_diag(cmd);
    ev = 1'b0;
    if (fl && !blk) begin
      if (m_v[vw][s] && m_m[vw][s]) begin
        ev = 1'b1;
        ln = line_pat(vw, s);
        for (int i = 0; i < 4; i++) m_cb[i] = ln[i*32 +: 32];
        m_cb[4] = {m_tag[vw][s], s, 4'h0};
      end
      m_tag[vw][s] = ad[31:12];
      m_v[vw][s] = 1'b1;
      m_m[vw][s] = aw;
      m_l[vw][s] = flk;
      m_lru[s] = !vw;
    end else if (!fl && eh) begin
      m_lru[s] = !hw;
      if (aw) m_m[hw][s] = 1'b1;
    end
    @(posedge clk);
    #2;
    chk("R9 error flag", 32'(dg_err), 32'(wr));
    chk("R6 copyback pulse", 32'(cb_valid), 32'(ev));
    if (rd) chk(cmd[9] ? "R8 copyback read" : "R7 tag read", dg_data, exp_dg);
  endtask

  task automatic idle_rd(input logic [9:0] cmd);
    step(0, 0, 32'd0, 0, 0, 1, 0, cmd);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 256; s++) m_tag[w][s] = '0;
    for (int i = 0; i < 5; i++) m_cb[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle_rd({2'b00, 8'h00});
    idle_rd({2'b01, 8'hFF});
    idle_rd({2'b10, 8'h04});
    idle_rd({2'b10, 8'h00});
    step(1, 0, 32'h1234_5670, 0, 0, 0, 0, '0);

    // R5/R6: dirty fill, second fill, lru touch, evictions
    step(1, 1, 32'h0000_1050, 1, 0, 0, 0, '0);
    step(1, 0, 32'h0000_2050, 1, 0, 0, 0, '0);
    step(1, 0, 32'h0000_1050, 0, 0, 1, 0, {2'b00, 8'h05}); // R4
    step(1, 0, 32'h0000_3050, 1, 0, 1, 0, {2'b01, 8'h05});
    step(1, 1, 32'h0000_3050, 0, 0, 0, 0, '0);             // R5 write hit
    step(1, 0, 32'h0000_4050, 1, 0, 0, 0, '0);             // evicts dirty line
    for (int i = 0; i < 5; i++) idle_rd({2'b10, 8'(i)});   // R8 words and address
    idle_rd({2'b10, 8'h05});
    idle_rd({2'b10, 8'hFF});
    step(1, 0, 32'h0000_5050, 1, 0, 0, 0, '0);
    idle_rd({2'b10, 8'h04});

    // R3: both ways locked
    step(1, 1, 32'h0000_1090, 1, 1, 0, 0, '0);
    step(1, 1, 32'h0000_2090, 1, 1, 0, 0, '0);
    step(1, 0, 32'h0000_3090, 1, 0, 1, 0, {2'b00, 8'h09});
    idle_rd({2'b01, 8'h09});
    idle_rd({2'b10, 8'h04});

    // R9: illegal write changes nothing
    step(0, 0, 32'd0, 0, 0, 0, 1, {2'b00, 8'h09});
    idle_rd({2'b00, 8'h09});
    step(0, 0, 32'd0, 0, 0, 1, 1, {2'b10, 8'h00});

    // random mix
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r, a, t;
      logic [9:0] c;
      bit hw, fl;
      r = $urandom;
      case (r[1:0])
        2'd0: t = 32'h0000_1000;
        2'd1: t = 32'h0000_2000;
        2'd2: t = 32'h0000_3000;
        default: t = 32'hABCD_E000;
      endcase
      case (r[3:2])
        2'd0: a = t | 32'h000;
        2'd1: a = t | 32'h010;
        2'd2: a = t | 32'hFF0;
        default: a = t | {20'd0, 8'(r[11:4] & 8'h07), 4'h0};
      endcase
      a = a | 32'(r[15:12]);
      fl = !m_hit(a, hw) && (r[17:16] != 2'd0);
      c = {r[18], r[19], (r[20] ? 8'(r[23:21]) : a[11:4])};
      step(r[24] | r[25], r[26], a, fl, (r[29:27] == 3'd0), r[30], (r[31] & r[18] & r[19]), c);
    end

    step(0, 0, 32'd0, 0, 0, 0, 0, '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule